// File: doc/BRIEF.md
# Sleep and Power-Gating Controller

This block sits beside a small processor core. It holds two byte-wide registers behind a simple register bus. The first is a sleep-control register, which holds the sleep enable, the sleep mode and the brown-out-off request. The second is a peripheral gating register. When the core executes its sleep instruction, it raises a one-cycle strobe. The block then decides whether to go to sleep and in which mode. It keeps that state until a wake event arrives.

Switching off the brown-out detector for a sleep is guarded. Software must first write the request bit together with a key bit. Within four cycles it must write the request bit again with the key bit clear. The request becomes effective three cycles after that second write. It stays effective for three cycles and then drops by itself. A sleep strobe that lands inside that interval marks the sleep as brown-out-off.

Four clock-enable outputs serve two timers, a serial interface and an ADC. Each enable follows its gating bit. All four enables are forced off during power-down sleep.

Top module: `sleep_pwr_ctl`

## Requirements
- R1: After reset, every register bit is zero, `sleeping`, `act_mode` and `bod_off` are 0, and `clk_en` is 4'b1111.
- R2: A write to address 1 stores `wdata[3:0]` as the gating bits, with bit 3 for timer 1, bit 2 for timer 0, bit 1 for the serial interface and bit 0 for the ADC. While not in power-down sleep, `clk_en[i]` equals the inverse of gating bit i. A read of address 1 returns the gating bits in bits 3:0, and bits 7:4 always read as zero.
- R3: In the control register at address 0, bit 0 is the sleep enable and bits 2:1 are the sleep mode. Bit 3 is the key and bit 4 is the brown-out-off request. A read returns the enable and the mode in their positions and the effective request in bit 4. Bit 3 and bits 7:5 always read as zero.
- R4: A write of 1 to both bit 4 and bit 3 opens the unlock window. It is followed by a write of bit 4 = 1 and bit 3 = 0 that lands 1 to 4 cycles later. Bit 4 then reads 1 starting three cycles after that second write, for exactly three cycles, and then reads 0 again.
- R5: A second write that lands 5 or more cycles after the first write does not set the request. Neither does an earlier write to address 0 with any other pattern, which closes the window.
- R6: The sleep strobe is ignored when the sleep enable is 0.
- R7: With the enable set and a mode other than 11, the strobe sets `sleeping` on the next cycle. `act_mode` then shows the mode: 00 idle, 01 ADC noise reduction, 10 power-down.
- R8: The strobe is ignored when the mode is the reserved value 11.
- R9: `bod_off` is set on entry only when the strobe arrives while the request is effective. It holds until wake.
- R10: While sleeping, a wake event clears `sleeping`, `act_mode` and `bod_off` on the next clock.
- R11: In power-down sleep, `clk_en` is 0. In idle sleep, `clk_en` still follows the gating bits.
- R12: While sleeping, further strobes and changes to the control register leave `act_mode` and `bod_off` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = control register, 1 = gating register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| sleep_req | input | 1 | One-cycle sleep-instruction strobe |
| wake_evt | input | 1 | Wake event |
| sleeping | output | 1 | Block is in a sleep state |
| act_mode | output | 2 | Mode of the current sleep |
| bod_off | output | 1 | Brown-out detector is off for this sleep |
| clk_en | output | 4 | Clock enables: timer 1, timer 0, serial, ADC |

## Verification
A wrong unlock counter shows up as a request bit at address 0 that appears one cycle early or late. It can also stay up for the wrong number of cycles, or appear after a late or malformed second write. The bench reads that bit on every cycle around the boundary, so an error of a single cycle is caught within six cycles of the second write. A wrong entry decision shows at `sleeping` one cycle after the strobe. Corrupted held state shows at `act_mode`, `bod_off` or `clk_en` while asleep, and the bench checks it before and after each wake.

// File: rtl/sleep_pwr_ctl.sv
module sleep_pwr_ctl #(
  parameter int UNLOCK_WIN = 4,
  parameter int ARM_DELAY  = 3,
  parameter int ARM_HOLD   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       sleep_req,
  input  logic       wake_evt,
  output logic       sleeping,
  output logic [1:0] act_mode,
  output logic       bod_off,
  output logic [3:0] clk_en
);
  localparam int WW = $clog2(UNLOCK_WIN + 1);
  localparam int DW = $clog2(ARM_DELAY + 1);
  localparam int HW = $clog2(ARM_HOLD + 1);
  localparam logic [1:0] MODE_PDOWN = 2'b10;
  localparam logic [1:0] MODE_RSVD  = 2'b11;

  logic          se;
  logic [1:0]    sm;
  logic [3:0]    pr;
  logic [WW-1:0] win_q;
  logic [DW-1:0] dly_q;
  logic [HW-1:0] hold_q;
  logic          arm_q;

  wire ctrl_wr   = bus_we && !bus_addr;
  wire gate_wr   = bus_we && bus_addr;
  wire first_wr  = ctrl_wr && bus_wdata[4] && bus_wdata[3];
  wire second_wr = ctrl_wr && bus_wdata[4] && !bus_wdata[3] && (win_q != '0);
  wire enter     = sleep_req && !sleeping && se && (sm != MODE_RSVD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      se <= 1'b0;
      sm <= 2'b00;
      pr <= 4'h0;
    end else begin
      if (ctrl_wr) begin
        se <= bus_wdata[0];
        sm <= bus_wdata[2:1];
      end
      if (gate_wr) pr <= bus_wdata[3:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                win_q <= '0;
    else if (first_wr)         win_q <= WW'(UNLOCK_WIN);
    else if (ctrl_wr)          win_q <= '0;
    else if (win_q != '0)      win_q <= win_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                dly_q <= '0;
    else if (second_wr)        dly_q <= DW'(ARM_DELAY);
    else if (dly_q != '0)      dly_q <= dly_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_q  <= 1'b0;
      hold_q <= '0;
    end else if (dly_q == DW'(1)) begin
      arm_q  <= 1'b1;
      hold_q <= HW'(ARM_HOLD);
    end else if (hold_q != '0) begin
      hold_q <= hold_q - 1'b1;
      if (hold_q == HW'(1)) arm_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sleeping <= 1'b0;
      act_mode <= 2'b00;
      bod_off  <= 1'b0;
    end else if (sleeping && wake_evt) begin
      sleeping <= 1'b0;
      act_mode <= 2'b00;
      bod_off  <= 1'b0;
    end else if (enter) begin
      sleeping <= 1'b1;
      act_mode <= sm;
      bod_off  <= arm_q;
    end
  end

  assign clk_en    = (sleeping && act_mode == MODE_PDOWN) ? 4'h0 : ~pr;
  assign bus_rdata = bus_addr ? {4'h0, pr} : {3'b000, arm_q, 1'b0, sm, se};

  p_arm_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arm_q) |=> arm_q ##1 arm_q ##1 !arm_q);
  p_no_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req && !sleeping && !se |=> !sleeping);
  p_rsvd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req && !sleeping && sm == MODE_RSVD |=> !sleeping);
  p_bod_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bod_off) |-> $past(arm_q));
  p_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sleeping && wake_evt |=> !sleeping && !bod_off && act_mode == 2'b00);
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sleeping && !wake_evt |=> sleeping && $stable(act_mode) && $stable(bod_off));
endmodule

// File: tb/sim_sleep_pwr_ctl.sv
module sim_sleep_pwr_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       sleep_req = 1'b0;
  logic       wake_evt = 1'b0;
  logic       sleeping;
  logic [1:0] act_mode;
  logic       bod_off;
  logic [3:0] clk_en;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  int         q_kind[$];
  logic [7:0] q_val[$];
  string      q_tag[$];

  always #4 clk = ~clk;

  sleep_pwr_ctl u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sleep_req(sleep_req),
    .wake_evt(wake_evt), .sleeping(sleeping), .act_mode(act_mode),
    .bod_off(bod_off), .clk_en(clk_en)
  );

  always @(negedge clk) begin
    while (q_kind.size() > 0) begin
      int k;
      logic [7:0] e;
      logic [7:0] o;
      string t;
      k = q_kind.pop_front();
      e = q_val.pop_front();
      t = q_tag.pop_front();
      case (k)
        0: o = {7'b0, sleeping};
        1: o = {6'b0, act_mode};
        2: o = {7'b0, bod_off};
        3: o = {4'b0, clk_en};
        default: o = bus_rdata;
      endcase
      n_cmp++;
      if (o !== e) begin
        n_bad++;
        $display("FAIL %s: item %0d got %0h expected %0h", t, k, o, e);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_we = 1'b0;
  endtask

  task automatic strobe();
    sleep_req = 1'b1; tick(); sleep_req = 1'b0;
  endtask

  task automatic wake();
    wake_evt = 1'b1; tick(); wake_evt = 1'b0;
  endtask

  task automatic push(input int k, input logic [7:0] e, input string t);
    q_kind.push_back(k); q_val.push_back(e); q_tag.push_back(t);
  endtask

  task automatic chk(input int k, input logic [7:0] e, input string t);
    push(k, e, t);
    @(negedge clk);
  endtask

  task automatic rd(input logic a, input logic [7:0] e, input string t);
    bus_addr = a;
    push(4, e, t);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    push(0, 8'h00, "R1"); push(1, 8'h00, "R1"); push(2, 8'h00, "R1");
    chk(3, 8'h0F, "R1");
    rd(1'b0, 8'h00, "R1");
    rd(1'b1, 8'h00, "R1");

    // R2 gating bits
    wr(1'b1, 8'hF5);
    chk(3, 8'h0A, "R2");
    rd(1'b1, 8'h05, "R2");
    wr(1'b1, 8'h0A);
    chk(3, 8'h05, "R2");
    wr(1'b1, 8'h00);

    // R3 control readback
    wr(1'b0, 8'hE5);
    rd(1'b0, 8'h05, "R3");

    // R6 strobe without enable
    wr(1'b0, 8'h02);
    strobe();
    chk(0, 8'h00, "R6");

    // R7 entry, R12 hold, R10 wake
    wr(1'b0, 8'h03);
    strobe();
    push(0, 8'h01, "R7"); push(1, 8'h01, "R7"); chk(2, 8'h00, "R7");
    wr(1'b0, 8'h05);
    strobe();
    push(0, 8'h01, "R12"); chk(1, 8'h01, "R12");
    wake();
    push(0, 8'h00, "R10"); push(1, 8'h00, "R10"); chk(2, 8'h00, "R10");

    // R11 power-down and idle gating
    wr(1'b1, 8'h03);
    wr(1'b0, 8'h05);
    strobe();
    push(1, 8'h02, "R11"); chk(3, 8'h00, "R11");
    wake();
    chk(3, 8'h0C, "R11");
    wr(1'b0, 8'h01);
    strobe();
    push(0, 8'h01, "R11"); chk(3, 8'h0C, "R11");
    wake();
    wr(1'b1, 8'h00);

    // R8 reserved mode
    wr(1'b0, 8'h07);
    strobe();
    chk(0, 8'h00, "R8");

    // R4 unlock, second write one cycle later
    wr(1'b0, 8'h18);
    wr(1'b0, 8'h10);
    bus_addr = 1'b0;
    rd(1'b0, 8'h00, "R4");
    tick(); rd(1'b0, 8'h00, "R4");
    tick(); rd(1'b0, 8'h00, "R4");
    tick(); rd(1'b0, 8'h10, "R4");
    tick(); rd(1'b0, 8'h10, "R4");
    tick(); rd(1'b0, 8'h10, "R4");
    tick(); rd(1'b0, 8'h00, "R4");

    // R4 boundary: second write four cycles after the first
    wr(1'b0, 8'h18);
    tick(); tick(); tick();
    wr(1'b0, 8'h10);
    tick(); tick();
    rd(1'b0, 8'h00, "R4");
    tick(); rd(1'b0, 8'h10, "R4");
    repeat (4) tick();

    // R5 late second write
    wr(1'b0, 8'h18);
    repeat (4) tick();
    wr(1'b0, 8'h10);
    for (int i = 0; i < 6; i++) begin
      rd(1'b0, 8'h00, "R5");
      tick();
    end

    // R5 wrong pattern closes the window
    wr(1'b0, 8'h18);
    wr(1'b0, 8'h00);
    wr(1'b0, 8'h10);
    for (int i = 0; i < 6; i++) begin
      rd(1'b0, 8'h00, "R5");
      tick();
    end

    // R9 strobe while request effective
    wr(1'b0, 8'h19);
    wr(1'b0, 8'h11);
    tick(); tick(); tick();
    strobe();
    push(0, 8'h01, "R9"); chk(2, 8'h01, "R9");
    tick(); tick();
    chk(2, 8'h01, "R9");
    wake();
    chk(2, 8'h00, "R9");

    // R9 strobe after request expired
    wr(1'b0, 8'h19);
    wr(1'b0, 8'h11);
    repeat (6) tick();
    strobe();
    push(0, 8'h01, "R9"); chk(2, 8'h00, "R9");
    wake();

    tick();
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule